// File: doc/BRIEF.md
# 64-byte direct store engine

This block moves one 64-byte line from a source address to a destination address. A caller presents both addresses with a start request. The engine first gathers the source bytes through an 8-byte read port. Then it has any cached copy of the destination line flushed and invalidated through a cache-control request/acknowledge port. Last, it sends the whole line to the memory port as one wide write.

The source may sit at any byte address. When it does not start on an 8-byte boundary, the engine fetches one extra beat and extracts the 64 wanted bytes from a staging buffer. The destination must start on a 64-byte boundary. If it does not, the operation ends at once with a fault and no port is touched.

Every outgoing request uses a valid/ready handshake. The engine keeps each request's address and data unchanged while it waits for ready. It never loads the destination line into a cache, and it never reads the destination line from memory.

Top module: `wide_store_engine`

## Requirements
- R1: A start whose destination has any of its low 6 bits set raises `fault` for exactly one cycle, in the cycle after acceptance. That operation raises no read, flush or write request and no `done`.
- R2: For any source byte offset, byte i of `wr_data` (bits 8i+7 down to 8i) equals the source byte at address src+i.
- R3: Source reads are 8-byte beats. Each beat address has its low 3 bits at zero. The beat addresses rise by 8, starting at src rounded down to a multiple of 8. The engine issues 8 beats when the low 3 bits of src are zero and 9 beats otherwise. Read responses return in request order, one per accepted request, in any later cycle.
- R4: The engine raises neither the flush request nor the write until every read response of the operation has arrived.
- R5: Each operation makes exactly one flush-invalidate request, carrying the destination address. The write is not raised until `cc_ack` has been received. `cc_ack` arrives in a cycle after the one in which the request was accepted.
- R6: Each aligned operation makes exactly one write handshake, carrying all 64 bytes at the destination address.
- R7: A read, flush or write request stays valid, with its address and data unchanged, until ready is seen.
- R8: A start is accepted when `start_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the `done` or `fault` cycle. While `busy` is high, `start_valid` is ignored.
- R9: `done` is high for exactly one cycle, in the cycle after the write handshake.
- R10: After reset, `busy`, `done`, `fault` and all request valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request |
| start_src | input | AW | Source byte address |
| start_dst | input | AW | Destination byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle misaligned-destination pulse |
| rd_req_valid | output | 1 | Read beat request valid |
| rd_req_ready | input | 1 | Read port accepts request |
| rd_req_addr | output | AW | Beat-aligned read address |
| rd_rsp_valid | input | 1 | Read beat data valid |
| rd_rsp_data | input | 64 | Read beat data, byte 0 in low bits |
| cc_req_valid | output | 1 | Flush-invalidate request valid |
| cc_req_ready | input | 1 | Cache control accepts request |
| cc_req_addr | output | AW | Line to flush and invalidate |
| cc_ack | input | 1 | Flush-invalidate finished |
| wr_valid | output | 1 | Line write valid |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | AW | Line write address |
| wr_data | output | 512 | Line write data, byte 0 in low bits |

## Verification
The hardest cases to reach are the ones where the ordering guarantees could break under back-pressure. One is a read request stalled while earlier responses are already returning. Another is a flush acknowledge that comes long after acceptance, with the write port also stalling. To reach them, the stimulus drives the read and write ready lines from a pseudo-random sequence and gives the cache model a programmable acknowledge delay. It also repeats the copy at source offsets 0, 3, 7 and 1, the last near the top of the address space. A second start is held during a long flush wait to show that it leaves no trace on the ports.

// File: rtl/wse_pkg.sv
package wse_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FAULT,
    S_READ,
    S_FLUSH_REQ,
    S_FLUSH_WAIT,
    S_WRITE,
    S_DONE
  } wse_state_e;

  // Beats needed to cover a line when the source sits 'off' bytes into a beat.
  function automatic int unsigned beats_for(input int unsigned off,
                                            input int unsigned line_beats);
    return (off == 0) ? line_beats : line_beats + 1;
  endfunction

  // True when any address bit below the line size is set.
  function automatic logic misaligned(input logic [63:0] addr,
                                      input int unsigned line_bits);
    logic [63:0] mask;
    mask = (64'd1 << line_bits) - 64'd1;
    return |(addr & mask);
  endfunction

endpackage

// File: rtl/wse_read_sequencer.sv
module wse_read_sequencer #(
  parameter int unsigned AW         = 48,
  parameter int unsigned BEAT_BYTES = 8,
  parameter int unsigned MAX_BEATS  = 9,
  localparam int unsigned OFFW      = $clog2(BEAT_BYTES),
  localparam int unsigned IDXW      = $clog2(MAX_BEATS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            clear,
  input  logic [AW-1:0]   launch_base,
  input  logic [IDXW-1:0] launch_count,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [AW-1:0]   rd_req_addr,
  input  logic            rd_rsp_valid,
  output logic            beat_we,
  output logic [IDXW-1:0] beat_idx,
  output logic            reads_done
);

  logic            active_q;
  logic [AW-1:0]   base_q;
  logic [IDXW-1:0] count_q;
  logic [IDXW-1:0] req_idx_q;
  logic [IDXW-1:0] rsp_idx_q;

  assign rd_req_valid = active_q && (req_idx_q < count_q);
  assign rd_req_addr  = base_q + (AW'(req_idx_q) << OFFW);
  assign beat_we      = active_q && rd_rsp_valid && (rsp_idx_q < count_q);
  assign beat_idx     = rsp_idx_q;
  assign reads_done   = active_q && (rsp_idx_q == count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      count_q   <= '0;
      req_idx_q <= '0;
      rsp_idx_q <= '0;
    end else if (clear) begin
      active_q <= 1'b0;
    end else if (launch) begin
      active_q  <= 1'b1;
      base_q    <= launch_base;
      count_q   <= launch_count;
      req_idx_q <= '0;
      rsp_idx_q <= '0;
    end else if (active_q) begin
      if (rd_req_valid && rd_req_ready) req_idx_q <= req_idx_q + 1'b1;
      if (beat_we)                      rsp_idx_q <= rsp_idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/wse_stage_assembler.sv
module wse_stage_assembler #(
  parameter int unsigned BEAT_BYTES = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAX_BEATS  = 9,
  localparam int unsigned BW        = BEAT_BYTES * 8,
  localparam int unsigned LW        = LINE_BYTES * 8,
  localparam int unsigned FW        = MAX_BEATS * BW,
  localparam int unsigned OFFW      = $clog2(BEAT_BYTES),
  localparam int unsigned IDXW      = $clog2(MAX_BEATS + 1)
) (
  input  logic            clk,
  input  logic            beat_we,
  input  logic [IDXW-1:0] beat_idx,
  input  logic [BW-1:0]   beat_data,
  input  logic [OFFW-1:0] byte_shift,
  output logic [LW-1:0]   line_out
);

  logic [FW-1:0] flat;

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
    logic [BW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (beat_we && (beat_idx == IDXW'(g))) slot_q <= beat_data;
    end
    assign flat[g*BW +: BW] = slot_q;
  end

  // Drop the leading bytes of the first beat; the rest follow in order.
  assign line_out = LW'(flat >> {byte_shift, 3'b000});

endmodule

// File: rtl/wide_store_engine.sv
module wide_store_engine
  import wse_pkg::*;
#(
  parameter int unsigned AW         = 48,
  parameter int unsigned BEAT_BYTES = 8,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned BW        = BEAT_BYTES * 8,
  localparam int unsigned LW        = LINE_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic [AW-1:0] start_src,
  input  logic [AW-1:0] start_dst,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [BW-1:0] rd_rsp_data,
  output logic          cc_req_valid,
  input  logic          cc_req_ready,
  output logic [AW-1:0] cc_req_addr,
  input  logic          cc_ack,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] wr_data
);

  localparam int unsigned LINE_BEATS = LINE_BYTES / BEAT_BYTES;
  localparam int unsigned MAX_BEATS  = LINE_BEATS + 1;
  localparam int unsigned OFFW       = $clog2(BEAT_BYTES);
  localparam int unsigned LOFFW      = $clog2(LINE_BYTES);
  localparam int unsigned IDXW       = $clog2(MAX_BEATS + 1);

  wse_state_e      state_q;
  logic [AW-1:0]   dst_q;
  logic [OFFW-1:0] off_q;
  logic            flush_seen;

  // Named events for the checker.
  logic            accept;
  logic            dst_bad;
  logic            launch;
  logic            reads_done;
  logic            beat_we;
  logic [IDXW-1:0] beat_idx;
  logic [AW-1:0]   src_base;
  logic [IDXW-1:0] src_beats;

  assign accept    = start_valid && (state_q == S_IDLE);
  assign dst_bad   = misaligned(64'(start_dst), LOFFW);
  assign launch    = accept && !dst_bad;
  assign src_base  = {start_src[AW-1:OFFW], {OFFW{1'b0}}};
  assign src_beats = IDXW'(beats_for(int'(start_src[OFFW-1:0]), LINE_BEATS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      dst_q      <= '0;
      off_q      <= '0;
      flush_seen <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          dst_q   <= start_dst;
          off_q   <= start_src[OFFW-1:0];
          state_q <= dst_bad ? S_FAULT : S_READ;
        end
        S_FAULT:      state_q <= S_IDLE;
        S_READ:       if (reads_done) state_q <= S_FLUSH_REQ;
        S_FLUSH_REQ:  if (cc_req_ready) state_q <= S_FLUSH_WAIT;
        S_FLUSH_WAIT: if (cc_ack) begin
          flush_seen <= 1'b1;
          state_q    <= S_WRITE;
        end
        S_WRITE:      if (wr_ready) state_q <= S_DONE;
        S_DONE: begin
          flush_seen <= 1'b0;
          state_q    <= S_IDLE;
        end
        default:      state_q <= S_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign done         = (state_q == S_DONE);
  assign fault        = (state_q == S_FAULT);
  assign cc_req_valid = (state_q == S_FLUSH_REQ);
  assign cc_req_addr  = dst_q;
  assign wr_valid     = (state_q == S_WRITE);
  assign wr_addr      = dst_q;

  wse_read_sequencer #(
    .AW(AW), .BEAT_BYTES(BEAT_BYTES), .MAX_BEATS(MAX_BEATS)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .clear        (done),
    .launch_base  (src_base),
    .launch_count (src_beats),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .beat_we      (beat_we),
    .beat_idx     (beat_idx),
    .reads_done   (reads_done)
  );

  wse_stage_assembler #(
    .BEAT_BYTES(BEAT_BYTES), .LINE_BYTES(LINE_BYTES), .MAX_BEATS(MAX_BEATS)
  ) asm_i (
    .clk        (clk),
    .beat_we    (beat_we),
    .beat_idx   (beat_idx),
    .beat_data  (rd_rsp_data),
    .byte_shift (off_q),
    .line_out   (wr_data)
  );

endmodule

// File: rtl/wse_checker.sv
module wse_checker #(
  parameter int unsigned AW    = 48,
  parameter int unsigned LW    = 512,
  parameter int unsigned BOFFW = 3,
  parameter int unsigned LOFFW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          cc_req_valid,
  input logic          cc_req_ready,
  input logic [AW-1:0] cc_req_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [LW-1:0] wr_data,
  input logic          reads_done,
  input logic          flush_seen
);

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_cc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cc_req_valid && !cc_req_ready |=> cc_req_valid && $stable(cc_req_addr));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_fault_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !rd_req_valid && !cc_req_valid && !wr_valid && !done);

  assert_fault_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  assert_rd_beat_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[BOFFW-1:0] == '0));

  assert_flush_after_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cc_req_valid |-> reads_done && !rd_req_valid);

  assert_write_after_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> reads_done);

  assert_write_after_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> flush_seen);

  assert_wr_line_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[LOFFW-1:0] == '0));

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !cc_req_valid && !wr_valid);

endmodule

bind wide_store_engine wse_checker #(
  .AW(AW), .LW(LW), .BOFFW(OFFW), .LOFFW(LOFFW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .fault        (fault),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .cc_req_valid (cc_req_valid),
  .cc_req_ready (cc_req_ready),
  .cc_req_addr  (cc_req_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .reads_done   (reads_done),
  .flush_seen   (flush_seen)
);

// File: tb/wide_store_engine_tb_top.sv
`timescale 1ns/100ps
module wide_store_engine_tb_top;

  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic [AW-1:0] start_src = '0;
  logic [AW-1:0] start_dst = '0;
  logic          busy, done, fault;
  logic          rd_req_valid, rd_req_ready;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [63:0]   rd_rsp_data = '0;
  logic          cc_req_valid, cc_req_ready;
  logic [AW-1:0] cc_req_addr;
  logic          cc_ack = 1'b0;
  logic          wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [511:0]  wr_data;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  // Back-pressure controls, set by tasks.
  bit        stall_rd = 1'b0;
  bit        stall_wr = 1'b0;
  bit        stall_cc = 1'b0;
  int        cc_delay = 1;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  wide_store_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_src(start_src), .start_dst(start_dst),
    .busy(busy), .done(done), .fault(fault),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .cc_req_valid(cc_req_valid),
    .cc_req_ready(cc_req_ready), .cc_req_addr(cc_req_addr),
    .cc_ack(cc_ack), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign rd_req_ready = !stall_rd || lfsr[0];
  assign wr_ready     = !stall_wr || lfsr[3];
  assign cc_req_ready = !stall_cc || lfsr[5];

  // Memory read responder: one response the cycle after each accepted request.
  always @(posedge clk) begin
    rd_rsp_valid <= 1'b0;
    if (rst_n && rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      for (int j = 0; j < 8; j++) rd_rsp_data[8*j +: 8] <= pat(rd_req_addr + AW'(j));
    end
  end

  // Cache control model with a programmable acknowledge delay.
  int cc_cnt = 0;
  always @(posedge clk) begin
    cc_ack <= 1'b0;
    if (cc_req_valid && cc_req_ready) cc_cnt <= cc_delay;
    else if (cc_cnt != 0) begin
      cc_cnt <= cc_cnt - 1;
      if (cc_cnt == 1) cc_ack <= 1'b1;
    end
  end

  // Monitors: monotonically increasing event counts and last-seen values.
  int            cyc = 0;
  int            n_rd_hs = 0, n_rd_rsp = 0, n_cc_hs = 0, n_cc_ack = 0;
  int            n_wr_hs = 0, n_done = 0, n_fault = 0, n_hold_viol = 0;
  int            rsp_at_cc = 0, ack_at_wr = 0, rdhs_at_cc = 0;
  int            wr_cyc = 0, done_cyc = 0;
  logic [AW-1:0] rd_log [16];
  logic [AW-1:0] cc_addr_last = '0, wr_addr_last = '0;
  logic [511:0]  wr_data_last = '0;
  bit            p_rd = 0, p_cc = 0, p_wr = 0;
  logic [AW-1:0] p_rd_a = '0, p_cc_a = '0, p_wr_a = '0;
  logic [511:0]  p_wr_d = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (p_rd && (!rd_req_valid || rd_req_addr != p_rd_a)) n_hold_viol <= n_hold_viol + 1;
      if (p_cc && (!cc_req_valid || cc_req_addr != p_cc_a)) n_hold_viol <= n_hold_viol + 1;
      if (p_wr && (!wr_valid || wr_addr != p_wr_a || wr_data != p_wr_d)) n_hold_viol <= n_hold_viol + 1;
      p_rd <= rd_req_valid && !rd_req_ready;  p_rd_a <= rd_req_addr;
      p_cc <= cc_req_valid && !cc_req_ready;  p_cc_a <= cc_req_addr;
      p_wr <= wr_valid && !wr_ready;          p_wr_a <= wr_addr;  p_wr_d <= wr_data;
      if (rd_req_valid && rd_req_ready) begin
        rd_log[n_rd_hs[3:0]] <= rd_req_addr;
        n_rd_hs <= n_rd_hs + 1;
      end
      if (rd_rsp_valid) n_rd_rsp <= n_rd_rsp + 1;
      if (cc_req_valid && cc_req_ready) begin
        n_cc_hs <= n_cc_hs + 1; cc_addr_last <= cc_req_addr;
        rsp_at_cc <= n_rd_rsp; rdhs_at_cc <= n_rd_hs;
      end
      if (cc_ack) n_cc_ack <= n_cc_ack + 1;
      if (wr_valid && wr_ready) begin
        n_wr_hs <= n_wr_hs + 1; wr_addr_last <= wr_addr; wr_data_last <= wr_data;
        ack_at_wr <= n_cc_ack; wr_cyc <= cyc;
      end
      if (done) begin n_done <= n_done + 1; done_cyc <= cyc; end
      if (fault) n_fault <= n_fault + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic start_op(input logic [AW-1:0] src, input logic [AW-1:0] dst);
    @(negedge clk);
    start_valid = 1'b1; start_src = src; start_dst = dst;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !done && !fault, "R10",
          $sformatf("busy/done/fault act %b%b%b exp 000", busy, done, fault));
    check(!rd_req_valid && !cc_req_valid && !wr_valid, "R10",
          $sformatf("valids act %b%b%b exp 000", rd_req_valid, cc_req_valid, wr_valid));
  endtask

  task automatic t_copy(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                        input bit stall, input int ccd, input string name);
    int b_rd, b_rsp, b_cc, b_ack, b_wr, b_done, b_viol, nb, waited;
    logic [511:0] exp_d;
    logic [AW-1:0] base;
    bit seq_ok;
    stall_rd = stall; stall_wr = stall; stall_cc = stall; cc_delay = ccd;
    b_rd = n_rd_hs; b_rsp = n_rd_rsp; b_cc = n_cc_hs; b_ack = n_cc_ack;
    b_wr = n_wr_hs; b_done = n_done; b_viol = n_hold_viol;
    start_op(src, dst);
    check(busy, "R8", $sformatf("%s busy after accept act %b exp 1", name, busy));
    waited = 0;
    while (!done && waited < 600) begin @(negedge clk); waited++; end
    check(done, "R9", $sformatf("%s done seen act %b exp 1", name, done));
    @(negedge clk);
    check(!done && !busy, "R9", $sformatf("%s done/busy next cycle act %b%b exp 00", name, done, busy));
    repeat (2) @(negedge clk);
    nb = (src[2:0] == 0) ? 8 : 9;
    base = {src[AW-1:3], 3'b000};
    for (int i = 0; i < 64; i++) exp_d[8*i +: 8] = pat(src + AW'(i));
    check(n_rd_hs - b_rd == nb, "R3", $sformatf("%s read beats act %0d exp %0d", name, n_rd_hs - b_rd, nb));
    seq_ok = 1'b1;
    for (int k = 0; k < nb; k++)
      if (rd_log[4'(b_rd + k)] != base + AW'(8 * k)) seq_ok = 1'b0;
    check(seq_ok, "R3", $sformatf("%s beat address sequence from %h", name, base));
    check(rsp_at_cc - b_rsp == nb && rdhs_at_cc - b_rd == nb, "R4",
          $sformatf("%s responses before flush act %0d exp %0d", name, rsp_at_cc - b_rsp, nb));
    check(n_cc_hs - b_cc == 1 && cc_addr_last == dst, "R5",
          $sformatf("%s flush count/addr act %0d/%h exp 1/%h", name, n_cc_hs - b_cc, cc_addr_last, dst));
    check(ack_at_wr - b_ack == 1, "R5", $sformatf("%s acks before write act %0d exp 1", name, ack_at_wr - b_ack));
    check(n_wr_hs - b_wr == 1 && wr_addr_last == dst, "R6",
          $sformatf("%s write count/addr act %0d/%h exp 1/%h", name, n_wr_hs - b_wr, wr_addr_last, dst));
    check(wr_data_last == exp_d, "R2", $sformatf("%s data act %h exp %h", name, wr_data_last, exp_d));
    check(n_done - b_done == 1 && done_cyc == wr_cyc + 1, "R9",
          $sformatf("%s done count/lag act %0d/%0d exp 1/1", name, n_done - b_done, done_cyc - wr_cyc));
    check(n_hold_viol == b_viol, "R7", $sformatf("%s hold violations act %0d exp 0", name, n_hold_viol - b_viol));
  endtask

  task automatic t_fault(input logic [AW-1:0] dst);
    int b_rd, b_cc, b_wr, b_done, b_fault;
    b_rd = n_rd_hs; b_cc = n_cc_hs; b_wr = n_wr_hs; b_done = n_done; b_fault = n_fault;
    start_op(48'h4321, dst);
    check(fault && busy, "R1", $sformatf("dst %h fault/busy act %b%b exp 11", dst, fault, busy));
    @(negedge clk);
    check(!fault && !busy, "R1", $sformatf("dst %h fault/busy after act %b%b exp 00", dst, fault, busy));
    repeat (4) @(negedge clk);
    check(n_fault - b_fault == 1 && n_done == b_done, "R1",
          $sformatf("dst %h fault/done pulses act %0d/%0d exp 1/0", dst, n_fault - b_fault, n_done - b_done));
    check(n_rd_hs == b_rd && n_cc_hs == b_cc && n_wr_hs == b_wr && !rd_req_valid, "R1",
          $sformatf("dst %h traffic rd/cc/wr act %0d/%0d/%0d exp 0/0/0", dst,
                    n_rd_hs - b_rd, n_cc_hs - b_cc, n_wr_hs - b_wr));
  endtask

  task automatic t_busy_ignore();
    int b_rd, b_wr, b_done, waited;
    stall_rd = 0; stall_wr = 0; stall_cc = 0; cc_delay = 30;
    b_rd = n_rd_hs; b_wr = n_wr_hs; b_done = n_done;
    start_op(48'h5000, 48'hC000);
    start_valid = 1'b1; start_src = 48'h6008; start_dst = 48'hD000;
    repeat (12) @(negedge clk);
    check(busy, "R8", $sformatf("still busy while second start held act %b exp 1", busy));
    start_valid = 1'b0;
    waited = 0;
    while (!done && waited < 600) begin @(negedge clk); waited++; end
    repeat (20) @(negedge clk);
    check(n_wr_hs - b_wr == 1 && wr_addr_last == 48'hC000, "R8",
          $sformatf("writes/addr act %0d/%h exp 1/c000", n_wr_hs - b_wr, wr_addr_last));
    check(n_rd_hs - b_rd == 8 && n_done - b_done == 1, "R8",
          $sformatf("reads/done act %0d/%0d exp 8/1", n_rd_hs - b_rd, n_done - b_done));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_copy(48'h1000, 48'h8000, 1'b0, 1, "aligned");
    t_copy(48'h2003, 48'h9040, 1'b1, 5, "offset3");
    t_copy(48'h30FF, 48'hA0C0, 1'b1, 2, "offset7");
    t_copy(48'h7FFF_FFFF_FFF9, 48'hFFFF_FFFF_FFC0, 1'b1, 9, "high");
    t_fault(48'hB001);
    t_fault(48'hB020);
    t_busy_ignore();
    t_copy(48'h0, 48'h40, 1'b0, 1, "after_ignore");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

endmodule